// File: doc/BRIEF.md
# Trap Return Privilege Unit

This block carries out the two trap-return operations of a processor with machine, supervisor and user privilege levels: the return from a machine-level trap and the return from a supervisor-level trap. A one-cycle request strobe comes with a select bit that picks the operation. Alongside it the block samples the current privilege level, the interrupt-enable and previous-privilege status bits, the trap-return-blocking bit, both saved exception return addresses, and a flag that says whether 16-bit compressed instructions are supported.

The block checks the request for legality in a fixed order. A legal request produces a pulse that commits the rewritten status bits and the new privilege level. An illegal request produces an exception pulse with a cause code, and the status and privilege outputs then repeat the sampled inputs unchanged. Every result is registered and appears on the clock edge that samples the request.

Top module: `trap_return_unit`

## Requirements
- R1: A machine-level return (`ret_is_sret`=0) requested while `cur_priv` is not machine raises an exception with cause 2 (illegal instruction) and commits nothing.
- R2: A supervisor-level return (`ret_is_sret`=1) requested in user mode raises an exception with cause 2.
- R3: A supervisor-level return in supervisor mode with `st_tsr`=1 raises cause 2. In machine mode the same return is legal whatever `st_tsr` holds.
- R4: When `rvc_en`=0 and bits [1:0] of the selected return address are not 00, cause 0 (instruction address misaligned) is raised. When `rvc_en`=1, the low address bits never cause a fault.
- R5: The checks are applied in this order: privilege level first, then alignment, then the blocking bit. Only the first check that fails decides the cause.
- R6: A legal machine-level return sets the new privilege to the old MPP, MIE to the old MPIE, MPIE to 1 and MPP to 00. The supervisor bits pass through unchanged.
- R7: A legal supervisor-level return sets the new privilege to {0, SPP}, SIE to the old SPIE, SPIE to 1 and SPP to 0. The machine bits pass through unchanged.
- R8: `ret_pc` takes `mepc` for a machine-level return and `sepc` for a supervisor-level return, and it is loaded on every request.
- R9: All outputs are registered. `exc_valid` and `upd_valid` are high for exactly one cycle after a request and are never high together. After an exception the status and privilege outputs equal the sampled inputs. Without a request, the valid outputs are 0 and the other outputs hold their values.
- R10: Privilege is encoded as U=00, S=01, M=11, and SPP encodes U as 0 and S as 1. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_req | input | 1 | One-cycle request strobe |
| ret_is_sret | input | 1 | 0 = machine-level return, 1 = supervisor-level return |
| cur_priv | input | 2 | Current privilege level |
| st_tsr | input | 1 | Blocks supervisor-level return in supervisor mode |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| mepc | input | XLEN | Machine saved return address |
| sepc | input | XLEN | Supervisor saved return address |
| rvc_en | input | 1 | Compressed instructions supported |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | CAUSE_W | Exception cause (0 when no fault) |
| upd_valid | output | 1 | Commit pulse for status and privilege |
| new_mie | output | 1 | Updated MIE |
| new_mpie | output | 1 | Updated MPIE |
| new_mpp | output | 2 | Updated MPP |
| new_sie | output | 1 | Updated SIE |
| new_spie | output | 1 | Updated SPIE |
| new_spp | output | 1 | Updated SPP |
| new_priv | output | 2 | Resulting privilege level |
| ret_pc | output | XLEN | Return target address |

## Verification
Every result of a request (exception flag and cause, commit pulse, rewritten status bits, new privilege and target address) is due exactly one rising edge after the cycle in which the request is driven. The bench drives inputs at the falling edge, lets one rising edge pass, and compares all outputs at the next falling edge against a behavioural model that is advanced once per cycle. Idle cycles are compared in the same way, which shows that the pulses drop back to 0 and that the other outputs hold their values.

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ret_req,
  input  logic               ret_is_sret,
  input  logic [1:0]         cur_priv,
  input  logic               st_tsr,
  input  logic               st_mie,
  input  logic               st_mpie,
  input  logic [1:0]         st_mpp,
  input  logic               st_sie,
  input  logic               st_spie,
  input  logic               st_spp,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  input  logic               rvc_en,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               upd_valid,
  output logic               new_mie,
  output logic               new_mpie,
  output logic [1:0]         new_mpp,
  output logic               new_sie,
  output logic               new_spie,
  output logic               new_spp,
  output logic [1:0]         new_priv,
  output logic [XLEN-1:0]    ret_pc
);
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = CAUSE_W'(2);

  logic [XLEN-1:0]    target;
  logic               priv_bad, misalign, tsr_bad, fault;
  logic [CAUSE_W-1:0] cause;

  assign target   = ret_is_sret ? sepc : mepc;
  assign priv_bad = ret_is_sret ? (cur_priv == PRIV_U) : (cur_priv != PRIV_M);
  assign misalign = !rvc_en && (target[1:0] != 2'b00);
  assign tsr_bad  = ret_is_sret && st_tsr && (cur_priv == PRIV_S);
  assign fault    = priv_bad || misalign || tsr_bad;
  assign cause    = priv_bad ? CAUSE_ILLEGAL : (misalign ? CAUSE_MISALIGN : CAUSE_ILLEGAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
      upd_valid <= 1'b0;
      new_mie   <= 1'b0;
      new_mpie  <= 1'b0;
      new_mpp   <= 2'b00;
      new_sie   <= 1'b0;
      new_spie  <= 1'b0;
      new_spp   <= 1'b0;
      new_priv  <= 2'b00;
      ret_pc    <= '0;
    end else begin
      exc_valid <= ret_req && fault;
      upd_valid <= ret_req && !fault;
      if (ret_req) begin
        exc_cause <= fault ? cause : '0;
        ret_pc    <= target;
        new_mie   <= st_mie;
        new_mpie  <= st_mpie;
        new_mpp   <= st_mpp;
        new_sie   <= st_sie;
        new_spie  <= st_spie;
        new_spp   <= st_spp;
        new_priv  <= cur_priv;
        if (!fault) begin
          if (ret_is_sret) begin
            new_priv <= {1'b0, st_spp};
            new_sie  <= st_spie;
            new_spie <= 1'b1;
            new_spp  <= 1'b0;
          end else begin
            new_priv <= st_mpp;
            new_mie  <= st_mpie;
            new_mpie <= 1'b1;
            new_mpp  <= PRIV_U;
          end
        end
      end
    end
  end

  a_r1_mret_below_m: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !ret_is_sret && cur_priv != PRIV_M) |=>
      (exc_valid && !upd_valid && exc_cause == CAUSE_ILLEGAL));

  a_r2_sret_from_u: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_is_sret && cur_priv == PRIV_U) |=>
      (exc_valid && exc_cause == CAUSE_ILLEGAL));

  a_r4_rvc_no_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && rvc_en && !ret_is_sret && cur_priv == PRIV_M) |=> upd_valid);

  a_r6_mret_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !ret_is_sret && cur_priv == PRIV_M && rvc_en) |=>
      (new_mpie && new_mpp == PRIV_U && new_mie == $past(st_mpie) && new_priv == $past(st_mpp)));

  a_r7_sret_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && $past(ret_is_sret) |->
      (new_spie && !new_spp && new_sie == $past(st_spie) && new_priv == {1'b0, $past(st_spp)}));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && upd_valid));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> (!exc_valid && !upd_valid && $stable(ret_pc) && $stable(new_priv)));
endmodule

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
  localparam int XLEN = 32;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ret_req, ret_is_sret, st_tsr, st_mie, st_mpie, st_sie, st_spie, st_spp, rvc_en;
  logic [1:0] cur_priv, st_mpp;
  logic [XLEN-1:0] mepc, sepc;
  logic exc_valid, upd_valid, new_mie, new_mpie, new_sie, new_spie, new_spp;
  logic [CW-1:0] exc_cause;
  logic [1:0] new_mpp, new_priv;
  logic [XLEN-1:0] ret_pc;

  always #4 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_sret(ret_is_sret),
    .cur_priv(cur_priv), .st_tsr(st_tsr), .st_mie(st_mie), .st_mpie(st_mpie),
    .st_mpp(st_mpp), .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp),
    .mepc(mepc), .sepc(sepc), .rvc_en(rvc_en), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .upd_valid(upd_valid), .new_mie(new_mie),
    .new_mpie(new_mpie), .new_mpp(new_mpp), .new_sie(new_sie), .new_spie(new_spie),
    .new_spp(new_spp), .new_priv(new_priv), .ret_pc(ret_pc));

  int n_cmp = 0;
  int n_bad = 0;

  logic e_exc, e_upd, e_mie, e_mpie, e_sie, e_spie, e_spp;
  logic [CW-1:0] e_cause;
  logic [1:0] e_mpp, e_priv;
  logic [XLEN-1:0] e_pc;

  task automatic model_step();
    logic [XLEN-1:0] t;
    int code;
    e_exc = 1'b0;
    e_upd = 1'b0;
    if (!ret_req) return;
    t = ret_is_sret ? sepc : mepc;
    code = -1;
    if (!ret_is_sret && cur_priv != 2'b11) code = 2;
    else if (ret_is_sret && cur_priv == 2'b00) code = 2;
    else if (!rvc_en && t[1:0] != 2'b00) code = 0;
    else if (ret_is_sret && cur_priv == 2'b01 && st_tsr) code = 2;
    e_pc = t;
    e_mie = st_mie; e_mpie = st_mpie; e_mpp = st_mpp;
    e_sie = st_sie; e_spie = st_spie; e_spp = st_spp; e_priv = cur_priv;
    if (code >= 0) begin
      e_exc = 1'b1;
      e_cause = CW'(code);
    end else begin
      e_upd = 1'b1;
      e_cause = '0;
      if (ret_is_sret) begin
        e_priv = st_spp ? 2'b01 : 2'b00;
        e_sie = st_spie; e_spie = 1'b1; e_spp = 1'b0;
      end else begin
        e_priv = st_mpp;
        e_mie = st_mpie; e_mpie = 1'b1; e_mpp = 2'b00;
      end
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if ({exc_valid, exc_cause, upd_valid} !== {e_exc, e_cause, e_upd} ||
        {new_mie, new_mpie, new_mpp, new_sie, new_spie, new_spp, new_priv} !==
        {e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp, e_priv} || ret_pc !== e_pc) begin
      n_bad++;
      $display("FAIL %s: got exc=%b cause=%0d upd=%b mie=%b mpie=%b mpp=%b sie=%b spie=%b spp=%b priv=%b pc=%h; want exc=%b cause=%0d upd=%b mie=%b mpie=%b mpp=%b sie=%b spie=%b spp=%b priv=%b pc=%h",
        tag, exc_valid, exc_cause, upd_valid, new_mie, new_mpie, new_mpp, new_sie, new_spie, new_spp, new_priv, ret_pc,
        e_exc, e_cause, e_upd, e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp, e_priv, e_pc);
    end
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    ret_req = 1'b0;
  endtask

  task automatic req(input logic s, input logic [1:0] p, input logic tsr, input logic rvc,
                     input logic [XLEN-1:0] m, input logic [XLEN-1:0] se, input string tag);
    ret_req = 1'b1; ret_is_sret = s; cur_priv = p; st_tsr = tsr; rvc_en = rvc;
    mepc = m; sepc = se;
    cycle(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ret_req = 1'b0; ret_is_sret = 1'b0; cur_priv = 2'b11; st_tsr = 1'b0;
    st_mie = 1'b0; st_mpie = 1'b1; st_mpp = 2'b01; st_sie = 1'b0; st_spie = 1'b1; st_spp = 1'b1;
    mepc = 32'h1000; sepc = 32'h2000; rvc_en = 1'b0;
    e_exc = 0; e_upd = 0; e_cause = '0; e_mie = 0; e_mpie = 0; e_mpp = 0;
    e_sie = 0; e_spie = 0; e_spp = 0; e_priv = 0; e_pc = '0;
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    cycle("R9 idle after reset");

    req(1'b0, 2'b11, 1'b0, 1'b0, 32'h1000, 32'h2000, "R6 mret legal");
    cycle("R9 idle hold");
    req(1'b0, 2'b01, 1'b0, 1'b0, 32'h1000, 32'h2000, "R1 mret from S");
    req(1'b0, 2'b00, 1'b0, 1'b0, 32'h1000, 32'h2000, "R1 mret from U");
    req(1'b1, 2'b00, 1'b0, 1'b1, 32'h1000, 32'h2000, "R2 sret from U");
    req(1'b1, 2'b01, 1'b1, 1'b0, 32'h1000, 32'h2000, "R3 sret S with tsr");
    req(1'b1, 2'b11, 1'b1, 1'b0, 32'h1000, 32'h2000, "R3 sret M with tsr");
    req(1'b1, 2'b01, 1'b0, 1'b0, 32'h1000, 32'h2004, "R7 sret legal");
    req(1'b0, 2'b11, 1'b0, 1'b0, 32'h1002, 32'h2000, "R4 mret misaligned");
    req(1'b0, 2'b11, 1'b0, 1'b1, 32'h1002, 32'h2000, "R4 mret rvc allowed");
    req(1'b1, 2'b01, 1'b0, 1'b0, 32'h1000, 32'h2001, "R4 sret misaligned");
    req(1'b1, 2'b01, 1'b1, 1'b0, 32'h1000, 32'h2003, "R5 misalign before tsr");
    req(1'b0, 2'b01, 1'b0, 1'b0, 32'h1001, 32'h2000, "R5 priv before misalign");
    req(1'b1, 2'b00, 1'b1, 1'b0, 32'h1000, 32'h2002, "R5 sret U priv first");
    st_spp = 1'b0;
    req(1'b1, 2'b11, 1'b0, 1'b0, 32'h1000, 32'h2008, "R7 sret to U");
    st_mpp = 2'b11;
    req(1'b0, 2'b11, 1'b0, 1'b0, 32'h3000, 32'h2008, "R8 mret target");
    cycle("R9 idle hold 2");

    for (int i = 0; i < 2000; i++) begin
      logic [1:0] pp;
      pp = 2'($urandom_range(0, 2));
      if (pp == 2'b10) pp = 2'b11;
      st_mie = 1'($urandom); st_mpie = 1'($urandom); st_sie = 1'($urandom);
      st_spie = 1'($urandom); st_spp = 1'($urandom);
      st_mpp = (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b11);
      if ($urandom_range(0, 3) == 0) cycle("R9 random idle");
      else req(1'($urandom), pp, 1'($urandom), 1'($urandom), $urandom, $urandom, "R5 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule